// File: doc/BRIEF.md
# Side-Effect Register File

This block holds the sixteen architectural registers of a small processor core. It offers two combinational read ports and one write port per cycle. Each register carries 16 data bits and one flag bit in bit 16. Most entries are plain storage, but several addresses have side effects. Address 12 comes out of reset holding 1. Address 13 counts down each time it is read as a source. Address 14 is the top of an eight-entry last-in-first-out stack. Address 15 is not storage: it reflects the program counter and flag supplied by fetch logic, and a write to it is turned into a one-cycle branch request.

The decode stage drives a read enable with each read address, and side effects happen only when that enable is set. Interrupt handling is supported by a shadow bank behind registers 0 to 7. An entry pulse copies them aside, and an exit pulse copies them back. The upper eight registers are not shadowed. Decoding which instruction is a return from interrupt, including the one that writes a zero upper byte into address 15, is left to the decode stage. That stage raises the exit pulse.

Top module: `spec_regfile`

## Requirements
- R1: After a synchronous active-low reset, address 12 reads 0x00001, every other stored address reads 0, the stack is empty, and branch_req is low.
- R2: Addresses 0 to 12 take wr_data (all 17 bits, flag in bit 16) at the clock edge when wr_en is set. Reads are combinational and show the value before any write in the same cycle.
- R3: An enabled read of address 13 on either port, or on both ports at once, lowers bits 15:0 by exactly one at the edge, wrapping from 0 to 0xFFFF and keeping bit 16. A write to address 13 in the same cycle takes precedence over the decrement.
- R4: Address 14 reads the top stack entry, or 0 when the stack is empty. An enabled read alone pops. A write alone pushes, and when 8 entries are held the oldest is discarded. A read and a write in the same cycle replace the top entry, or create one entry if the stack is empty. A pop when empty leaves the stack empty.
- R5: A read of address 15 returns {pc_flag, pc}. A write to address 15 changes no stored register.
- R6: A write to address 15 raises branch_req for exactly the following cycle, with branch_target equal to wr_data[15:0]. Without such a write, branch_req is low the following cycle.
- R7: isr_enter copies addresses 0 to 7 into the shadow bank, using their values from before any same-cycle write. The live registers are changed only by that write.
- R8: isr_exit, when isr_enter is low, loads addresses 0 to 7 from the shadow bank and overrides any same-cycle write to them. Addresses 8 to 13 and the stack are unaffected. isr_exit has no effect while isr_enter is high.
- R9: A read of address 13 or 14 with its read enable low returns the current value without changing any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en_a | input | 1 | Port A read is a real source use |
| rd_addr_a | input | 4 | Port A address |
| rd_en_b | input | 1 | Port B read is a real source use |
| rd_addr_b | input | 4 | Port B address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 17 | Write value, flag in bit 16 |
| pc | input | 16 | Current program counter |
| pc_flag | input | 1 | Current flag bit |
| isr_enter | input | 1 | Interrupt entry pulse |
| isr_exit | input | 1 | Interrupt exit pulse |
| rd_data_a | output | 17 | Port A read value |
| rd_data_b | output | 17 | Port B read value |
| branch_req | output | 1 | One-cycle branch request |
| branch_target | output | 16 | Branch address |

## Verification
Read data is combinational, so a read is due in the same cycle as its address. The bench compares it shortly before the rising edge, after inputs have settled from the falling edge. Every state change is due at that edge and shows up in reads one cycle later: decrement, push, pop, shadow copy and write. branch_req and branch_target come from one register stage and are compared in the cycle after the write. The behavioural model is updated right after each edge from the inputs that were present at it, so each comparison uses the model state that matches the cycle being sampled.

// File: rtl/spec_rf_pkg.sv
// Shared constants and types for the side-effect register file.
// Assumes a fixed 16-entry address space; special addresses are fixed.
package spec_rf_pkg;
    localparam int DATA_W      = 16;
    localparam int WORD_W      = DATA_W + 1;
    localparam int ADDR_W      = 4;
    localparam int STACK_DEPTH = 8;
    localparam int SHADOW_N    = 8;
    localparam int IDX_ONE     = 12;
    localparam int IDX_DEC     = 13;
    localparam int IDX_STK     = 14;
    localparam int IDX_PC      = 15;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rf_lifo.sv
// Shift-register stack behind the stack address.
// Entry 0 is the top. Positions at or beyond the depth always hold zero.
// Assumes push and pop are already qualified by the caller.
module rf_lifo #(
    parameter int W     = 17,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     top_data,
    output logic [CNT_W-1:0] depth_o
);
    logic [W-1:0]     ent [DEPTH];
    logic [CNT_W-1:0] depth_q;

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_ent
            // Move one entry for a push, pop, or replacement of the top.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent[i] <= '0;
                end else if (push && pop) begin
                    if (i == 0) ent[i] <= wr_data;
                end else if (push) begin
                    if (i == 0) ent[i] <= wr_data;
                    else        ent[i] <= ent[(i == 0) ? 0 : i - 1];
                end else if (pop) begin
                    if (i == DEPTH - 1) ent[i] <= '0;
                    else                ent[i] <= ent[(i == DEPTH - 1) ? i : i + 1];
                end
            end
        end
    endgenerate

    // Track how many entries are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push && pop) begin
            if (depth_q == '0) depth_q <= CNT_W'(1);
        end else if (push) begin
            if (depth_q != CNT_W'(DEPTH)) depth_q <= depth_q + CNT_W'(1);
        end else if (pop) begin
            if (depth_q != '0) depth_q <= depth_q - CNT_W'(1);
        end
    end

    assign top_data = (depth_q == '0) ? '0 : ent[0];
    assign depth_o  = depth_q;
endmodule

// File: rtl/rf_store_bank.sv
// Stored registers below the stack address.
// Handles the reset-to-one entry, the count-down entry and the shadow copies
// of the low entries. Assumes the caller gives dec_en only for enabled reads.
module rf_store_bank #(
    parameter int W        = 17,
    parameter int AW       = 4,
    parameter int NSTORE   = 14,
    parameter int SHADOW_N = 8,
    parameter int IDX_ONE  = 12,
    parameter int IDX_DEC  = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [W-1:0]           wr_data,
    input  logic                   dec_en,
    input  logic                   isr_enter,
    input  logic                   isr_exit,
    output logic [NSTORE-1:0][W-1:0] regs_o
);
    logic restore;
    assign restore = isr_exit && !isr_enter;

    genvar i;
    generate
        for (i = 0; i < NSTORE; i++) begin : g_reg
            logic [W-1:0] r_q;
            logic         hit;
            assign hit = wr_en && (wr_addr == AW'(i));

            if (i < SHADOW_N) begin : g_shadowed
                logic [W-1:0] sh_q;
                // Save the live value on interrupt entry.
                always_ff @(posedge clk) begin
                    if (!rst_n)         sh_q <= '0;
                    else if (isr_enter) sh_q <= r_q;
                end
                // Live value: restore has priority over a write.
                always_ff @(posedge clk) begin
                    if (!rst_n)       r_q <= (i == IDX_ONE) ? W'(1) : '0;
                    else if (restore) r_q <= sh_q;
                    else if (hit)     r_q <= wr_data;
                end
            end else if (i == IDX_DEC) begin : g_down
                // Count-down entry: a write wins over the decrement.
                always_ff @(posedge clk) begin
                    if (!rst_n)      r_q <= '0;
                    else if (hit)    r_q <= wr_data;
                    else if (dec_en) r_q <= {r_q[W-1], r_q[W-2:0] - (W-1)'(1)};
                end
            end else begin : g_plain
                // Plain entry, optionally reset to one.
                always_ff @(posedge clk) begin
                    if (!rst_n)   r_q <= (i == IDX_ONE) ? W'(1) : '0;
                    else if (hit) r_q <= wr_data;
                end
            end
            assign regs_o[i] = r_q;
        end
    endgenerate
endmodule

// File: rtl/spec_regfile.sv
// Register file top: two read ports, one write port.
// Routes each address to storage, the stack or the program counter, and turns
// writes to the program-counter address into a one-cycle branch request.
// Assumes rd_en_* mark real source uses; data is shown regardless of enable.
module spec_regfile
    import spec_rf_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = STACK_DEPTH,
    parameter int SHN   = SHADOW_N,
    localparam int WW    = DW + 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_a,
    input  logic [3:0]    rd_addr_a,
    input  logic          rd_en_b,
    input  logic [3:0]    rd_addr_b,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [WW-1:0] wr_data,
    input  logic [DW-1:0] pc,
    input  logic          pc_flag,
    input  logic          isr_enter,
    input  logic          isr_exit,
    output logic [WW-1:0] rd_data_a,
    output logic [WW-1:0] rd_data_b,
    output logic          branch_req,
    output logic [DW-1:0] branch_target
);
    localparam int NSTORE = IDX_STK;

    logic [NSTORE-1:0][WW-1:0] store_regs;
    logic [WW-1:0]             stk_top;
    logic [CNT_W-1:0]          stk_depth;
    logic [1:0][3:0]           addr_v;
    logic [1:0]                en_v;
    logic [1:0][WW-1:0]        data_v;
    logic                      dec_en, stk_rd, stk_wr;
    logic                      br_q;
    logic [DW-1:0]             tgt_q;

    assign addr_v = {rd_addr_b, rd_addr_a};
    assign en_v   = {rd_en_b, rd_en_a};

    // Side-effect qualifiers: either port counts once.
    assign dec_en = (rd_en_a && rd_addr_a == 4'(IDX_DEC)) || (rd_en_b && rd_addr_b == 4'(IDX_DEC));
    assign stk_rd = (rd_en_a && rd_addr_a == 4'(IDX_STK)) || (rd_en_b && rd_addr_b == 4'(IDX_STK));
    assign stk_wr = wr_en && (wr_addr == 4'(IDX_STK));

    rf_store_bank #(
        .W(WW), .AW(4), .NSTORE(NSTORE), .SHADOW_N(SHN),
        .IDX_ONE(IDX_ONE), .IDX_DEC(IDX_DEC)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dec_en(dec_en), .isr_enter(isr_enter),
        .isr_exit(isr_exit), .regs_o(store_regs)
    );

    rf_lifo #(.W(WW), .DEPTH(DEPTH)) u_lifo (
        .clk(clk), .rst_n(rst_n), .push(stk_wr), .pop(stk_rd),
        .wr_data(wr_data), .top_data(stk_top), .depth_o(stk_depth)
    );

    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_port
            // Select the read source for this port.
            always_comb begin
                if (addr_v[p] == 4'(IDX_PC))       data_v[p] = {pc_flag, pc};
                else if (addr_v[p] == 4'(IDX_STK)) data_v[p] = stk_top;
                else                               data_v[p] = store_regs[addr_v[p]];
            end
        end
    endgenerate

    assign rd_data_a = data_v[0];
    assign rd_data_b = data_v[1];

    // Register the branch request and its target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_q  <= 1'b0;
            tgt_q <= '0;
        end else begin
            br_q <= wr_en && (wr_addr == 4'(IDX_PC));
            if (wr_en && wr_addr == 4'(IDX_PC)) tgt_q <= wr_data[DW-1:0];
        end
    end

    assign branch_req    = br_q;
    assign branch_target = tgt_q;
endmodule

// File: rtl/spec_regfile_chk.sv
// Property checker for spec_regfile, attached by bind.
// Assumes the default address map from spec_rf_pkg.
module spec_regfile_chk #(
    parameter int DW    = 16,
    parameter int CNT_W = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en_a,
    input logic [3:0]    rd_addr_a,
    input logic          wr_en,
    input logic [3:0]    wr_addr,
    input logic [DW:0]   wr_data,
    input logic [DW-1:0] pc,
    input logic          pc_flag,
    input logic [DW:0]   rd_data_a,
    input logic          branch_req,
    input logic [DW-1:0] branch_target,
    input logic [CNT_W-1:0] stk_depth
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !branch_req); // R1

    AST_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_a && rd_addr_a == 4'd13 && !(wr_en && wr_addr == 4'd13)) ##1 (rd_en_a && rd_addr_a == 4'd13)
        |-> rd_data_a[DW-1:0] == DW'($past(rd_data_a[DW-1:0]) - DW'(1))); // R3

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_depth == '0 && rd_addr_a == 4'd14) |-> rd_data_a == '0); // R4

    AST_PC_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == 4'd15) |-> rd_data_a == {pc_flag, pc}); // R5

    AST_BRANCH_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd15) |=> (branch_req && branch_target == $past(wr_data[DW-1:0]))); // R6

    AST_BRANCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 4'd15) |=> !branch_req); // R6
endmodule

bind spec_regfile spec_regfile_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc(pc),
    .pc_flag(pc_flag), .rd_data_a(rd_data_a), .branch_req(branch_req),
    .branch_target(branch_target), .stk_depth(stk_depth)
);

// File: tb/spec_regfile_bench.sv
module spec_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en_a = 0, rd_en_b = 0, wr_en = 0;
    logic [3:0]  rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0;
    logic [16:0] wr_data = 0;
    logic [15:0] pc = 0;
    logic        pc_flag = 0;
    logic        isr_enter = 0, isr_exit = 0;
    logic [16:0] rd_data_a, rd_data_b;
    logic        branch_req;
    logic [15:0] branch_target;

    int n_checks = 0;
    int n_fail   = 0;
    string ph_tag = "R2";

    // Reference model state
    logic [16:0] m_reg [16];
    logic [16:0] m_sh  [8];
    logic [16:0] m_stk [$];
    logic        e_br;
    logic [15:0] e_tgt;

    always #4 clk = ~clk;

    spec_regfile u_spec_regfile (
        .clk(clk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a),
        .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pc(pc), .pc_flag(pc_flag),
        .isr_enter(isr_enter), .isr_exit(isr_exit), .rd_data_a(rd_data_a),
        .rd_data_b(rd_data_b), .branch_req(branch_req),
        .branch_target(branch_target)
    );

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [16:0] m_read(input logic [3:0] a);
        if (a == 15) return {pc_flag, pc};
        if (a == 14) return (m_stk.size() > 0) ? m_stk[0] : 17'h0;
        return m_reg[a];
    endfunction

    function automatic string tag_for(input logic [3:0] a, input logic en);
        if ((a == 13 || a == 14) && !en) return "R9";
        if (a == 13) return "R3";
        if (a == 14) return "R4";
        if (a == 15) return "R5";
        return ph_tag;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = (i == 12) ? 17'h1 : 17'h0;
        for (int i = 0; i < 8; i++) m_sh[i] = 17'h0;
        m_stk.delete();
        e_br = 0;
        e_tgt = 0;
    endtask

    // Advance the model by one edge using the inputs present at it.
    task automatic model_edge();
        logic r13, r14, w14;
        logic [16:0] old_lo [8];
        r13 = (rd_en_a && rd_addr_a == 13) || (rd_en_b && rd_addr_b == 13);
        r14 = (rd_en_a && rd_addr_a == 14) || (rd_en_b && rd_addr_b == 14);
        w14 = wr_en && wr_addr == 14;
        for (int i = 0; i < 8; i++) old_lo[i] = m_reg[i];
        if (wr_en && wr_addr < 14) m_reg[wr_addr] = wr_data;
        else if (r13) m_reg[13] = {m_reg[13][16], m_reg[13][15:0] - 16'd1};
        if (wr_en && wr_addr < 13 && r13) m_reg[13] = {m_reg[13][16], m_reg[13][15:0] - 16'd1};
        if (w14 && r14) begin
            if (m_stk.size() == 0) m_stk.push_front(wr_data);
            else m_stk[0] = wr_data;
        end else if (w14) begin
            m_stk.push_front(wr_data);
            if (m_stk.size() > 8) void'(m_stk.pop_back());
        end else if (r14 && m_stk.size() > 0) begin
            void'(m_stk.pop_front());
        end
        if (isr_exit && !isr_enter) for (int i = 0; i < 8; i++) m_reg[i] = m_sh[i];
        if (isr_enter) for (int i = 0; i < 8; i++) m_sh[i] = old_lo[i];
        e_br = wr_en && wr_addr == 15;
        if (e_br) e_tgt = wr_data[15:0];
    endtask

    task automatic step(input logic ea, input logic [3:0] aa, input logic eb, input logic [3:0] ab,
                        input logic we, input logic [3:0] wa, input logic [16:0] wd,
                        input logic ent, input logic ex);
        @(negedge clk);
        rd_en_a = ea; rd_addr_a = aa; rd_en_b = eb; rd_addr_b = ab;
        wr_en = we; wr_addr = wa; wr_data = wd; isr_enter = ent; isr_exit = ex;
        pc = 16'($urandom); pc_flag = 1'($urandom);
        #3;
        check(tag_for(aa, ea), rd_data_a, m_read(aa), "port A");
        check(tag_for(ab, eb), rd_data_b, m_read(ab), "port B");
        check("R6", {16'h0, branch_req}, {16'h0, e_br}, "branch_req");
        if (e_br) check("R6", {1'b0, branch_target}, {1'b0, e_tgt}, "branch_target");
        @(posedge clk);
        model_edge();
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] b);
        step(0, a, 0, b, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input logic [3:0] wa, input logic [16:0] wd);
        step(0, 0, 0, 0, 1, wa, wd, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int i = 0; i < 16; i += 2) rd(4'(i), 4'(i + 1));

        // R2: plain writes, no same-cycle bypass
        ph_tag = "R2";
        for (int i = 0; i < 13; i++) wr(4'(i), 17'h10000 | 17'(i * 16'h1111));
        step(1, 5, 1, 12, 1, 5, 17'h0ABCD, 0, 0);
        for (int i = 0; i < 13; i += 2) rd(4'(i), 4'(i + 1));

        // R3: count-down, both ports once, wrap, write wins
        wr(13, 17'h10001);
        step(1, 13, 1, 13, 0, 0, 0, 0, 0);
        step(1, 13, 0, 0, 0, 0, 0, 0, 0);
        step(0, 13, 1, 13, 0, 0, 0, 0, 0);
        step(1, 13, 0, 0, 1, 13, 17'h00042, 0, 0);
        rd(13, 13);

        // R9: disabled reads leave state alone
        rd(13, 14); rd(13, 14); rd(14, 13);

        // R4: overflow, empty pops, modify top
        for (int i = 0; i < 10; i++) wr(14, 17'(i + 1));
        for (int i = 0; i < 10; i++) step(1, 14, 0, 0, 0, 0, 0, 0, 0);
        step(1, 14, 1, 14, 1, 14, 17'h1F00F, 0, 0);
        step(1, 14, 0, 0, 1, 14, 17'h00777, 0, 0);
        rd(14, 14);
        wr(14, 17'h00123);
        step(0, 0, 1, 14, 1, 14, 17'h00321, 0, 0);
        step(1, 14, 0, 0, 0, 0, 0, 0, 0);
        step(1, 14, 0, 0, 0, 0, 0, 0, 0);

        // R5/R6: PC view and branch pulse
        wr(15, 17'h13FE0);
        rd(15, 12);
        wr(15, 17'h09F00);
        wr(15, 17'h00040);
        rd(15, 0);
        rd(12, 15);

        // R7: entry saves old values
        ph_tag = "R7";
        for (int i = 0; i < 8; i++) wr(4'(i), 17'(16'hA000 + i));
        step(0, 0, 0, 0, 1, 3, 17'h0DEAD, 1, 0);
        for (int i = 0; i < 8; i++) wr(4'(i), 17'(16'h5000 + i));
        wr(9, 17'h00999);
        // R8: exit restores, beats write; simultaneous enter ignores exit
        ph_tag = "R8";
        step(0, 0, 0, 0, 1, 2, 17'h0BEEF, 0, 1);
        for (int i = 0; i < 12; i += 2) rd(4'(i), 4'(i + 1));
        step(0, 0, 0, 0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 8; i += 2) rd(4'(i), 4'(i + 1));

        // Mixed random traffic
        ph_tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
                 1'($urandom), 4'($urandom), 17'($urandom),
                 ($urandom % 16) == 0, ($urandom % 16) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule